// File: doc/BRIEF.md
# Dual-Arm Integrate-and-Dump Accumulator

This block sums code-mixed baseband samples for one correlator channel. Two arms are accumulated side by side: a prompt arm and a tracking arm. Each arm has an in-phase and a quadrature component, so the block keeps four running sums. A single dump strobe ends an integration period for all four sums at once. On that strobe the sums move into four result registers and the new period begins.

The result registers can be read at any time. Nothing stops a later dump from replacing them part way through a read sequence. For this reason a fresh-data flag is set on every dump and cleared when software reads the last register of the set, the quadrature prompt result. A one-cycle interrupt pulse also follows every dump.

Samples are 3-bit signed codes. The integration period is limited to `MAX_PERIOD` samples, so that the 16-bit sums never leave their range.

Top module: `dual_arm_iad`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all four result outputs read 0, `new_data` is 0 and `accum_irq` is 0.
- R2: Each sample input is a 3-bit two's complement code: 3'b011 = +3, 3'b001 = +1, 3'b111 = −1, 3'b101 = −3. In every cycle without `dump`, each running sum adds its sample.
- R3: In the cycle after a cycle with `dump` high, each result output holds the sum of the samples from the previous dump cycle (or from reset release) up to, but not including, the current dump cycle. The result is a 16-bit two's complement value.
- R4: The sample present in a dump cycle is not lost. It becomes the first term of the new period.
- R5: `res_pi`/`res_pq` carry the prompt-arm I/Q sums from `p_i`/`p_q`. `res_ti`/`res_tq` carry the tracking-arm I/Q sums from `t_i`/`t_q`.
- R6: Between dumps the result outputs do not change, whatever the samples do.
- R7: `new_data` is 1 in the cycle after a dump. It keeps its value until a read or a dump changes it.
- R8: A `qp_read` pulse without `dump` clears `new_data` in the next cycle. A read while the flag is already clear changes nothing. When `dump` and `qp_read` come in the same cycle, the flag is set.
- R9: `accum_irq` is high for exactly the one cycle after each dump cycle, including back-to-back dumps.
- R10: Take a period of `MAX_PERIOD` (default 10922) samples, counting the dump cycle that opens it. With all samples at +3 the result is exactly +32766, and with all samples at −3 it is exactly −32766. No sum wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump | input | 1 | End-of-period strobe, one cycle |
| qp_read | input | 1 | Strobe marking a read of the quadrature prompt result |
| p_i | input | 3 | Prompt-arm in-phase sample |
| p_q | input | 3 | Prompt-arm quadrature sample |
| t_i | input | 3 | Tracking-arm in-phase sample |
| t_q | input | 3 | Tracking-arm quadrature sample |
| res_ti | output | 16 | Tracking-arm in-phase result |
| res_tq | output | 16 | Tracking-arm quadrature result |
| res_pi | output | 16 | Prompt-arm in-phase result |
| res_pq | output | 16 | Prompt-arm quadrature result |
| new_data | output | 1 | Fresh-result flag |
| accum_irq | output | 1 | One-cycle pulse after each dump |

## Verification
The hardest case to reach is the edge of the range: a full-length period that drives a sum to ±32766 without wrapping. The bench first issues a dump that opens a clean period. It then holds the prompt in-phase input at +3 and the tracking quadrature input at −3 for `MAX_PERIOD` cycles before the closing dump. The other hard case is the order between read and dump on the flag. The vector table places a read and a dump in the same cycle, a read while the flag is clear, and back-to-back dumps.

// File: rtl/dual_arm_iad.sv
module dual_arm_iad #(
  parameter int SW         = 3,
  parameter int AW         = 16,
  parameter int MAX_PERIOD = 10922
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dump,
  input  logic          qp_read,
  input  logic [SW-1:0] p_i,
  input  logic [SW-1:0] p_q,
  input  logic [SW-1:0] t_i,
  input  logic [SW-1:0] t_q,
  output logic [AW-1:0] res_ti,
  output logic [AW-1:0] res_tq,
  output logic [AW-1:0] res_pi,
  output logic [AW-1:0] res_pq,
  output logic          new_data,
  output logic          accum_irq
);
  localparam int NSUM = 4;
  localparam int EXT  = AW - SW;

  logic [SW-1:0] smp [NSUM];
  logic [AW-1:0] acc [NSUM];
  logic [AW-1:0] res [NSUM];

  assign smp[0] = t_i;
  assign smp[1] = t_q;
  assign smp[2] = p_i;
  assign smp[3] = p_q;

  for (genvar k = 0; k < NSUM; k++) begin : g_sum
    logic [AW-1:0] wide;
    assign wide = {{EXT{smp[k][SW-1]}}, smp[k]};
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc[k] <= '0;
        res[k] <= '0;
      end else if (dump) begin
        acc[k] <= wide;
        res[k] <= acc[k];
      end else begin
        acc[k] <= acc[k] + wide;
      end
    end
  end

  assign res_ti = res[0];
  assign res_tq = res[1];
  assign res_pi = res[2];
  assign res_pq = res[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_data  <= 1'b0;
      accum_irq <= 1'b0;
    end else begin
      accum_irq <= dump;
      if (dump)         new_data <= 1'b1;
      else if (qp_read) new_data <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_arm_iad_chk.sv
module dual_arm_iad_chk #(
  parameter int AW         = 16,
  parameter int MAX_PERIOD = 10922
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dump,
  input logic          qp_read,
  input logic [AW-1:0] res_ti,
  input logic [AW-1:0] res_tq,
  input logic [AW-1:0] res_pi,
  input logic [AW-1:0] res_pq,
  input logic          new_data,
  input logic          accum_irq
);
  logic [15:0] span;

  always_ff @(posedge clk) begin
    if (!rst_n)             span <= '0;
    else if (dump)          span <= 16'd1;
    else if (span != '1)    span <= span + 16'd1;
  end

  assert_irq_on_dump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> accum_irq);
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> !accum_irq);
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> new_data);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (qp_read && !dump) |=> !new_data);
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!qp_read && !dump) |=> (new_data == $past(new_data)));
  assert_results_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> $stable({res_ti, res_tq, res_pi, res_pq}));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dump |-> (span <= 16'(MAX_PERIOD)));
endmodule

bind dual_arm_iad dual_arm_iad_chk #(.AW(AW), .MAX_PERIOD(MAX_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .dump(dump), .qp_read(qp_read),
  .res_ti(res_ti), .res_tq(res_tq), .res_pi(res_pi), .res_pq(res_pq),
  .new_data(new_data), .accum_irq(accum_irq)
);

// File: tb/dual_arm_iad_tb.sv
module dual_arm_iad_tb;
  localparam int MAXP = 10922;
  localparam logic [2:0] P3 = 3'b011, P1 = 3'b001, M1 = 3'b111, M3 = 3'b101;
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, P3, P1, M1, M3},
    {1'b0, 1'b0, P1, M3, P3, M1},
    {1'b1, 1'b0, M1, M1, P1, P3},
    {1'b0, 1'b0, P3, P3, M3, M3},
    {1'b0, 1'b1, P1, M1, P1, M1},
    {1'b0, 1'b1, M3, P1, P3, P1},
    {1'b1, 1'b0, P3, M3, P1, M1},
    {1'b1, 1'b0, M1, P1, M3, P3},
    {1'b0, 1'b0, P1, P1, P1, P1},
    {1'b1, 1'b1, P3, P1, M1, M3},
    {1'b0, 1'b0, M3, M3, M3, M3},
    {1'b0, 1'b0, M3, M1, P3, P1},
    {1'b0, 1'b1, P1, P3, M1, M3},
    {1'b1, 1'b0, P1, M1, P1, M1},
    {1'b0, 1'b0, P3, P3, P3, P3},
    {1'b1, 1'b1, M1, M3, P3, P1}
  };

  logic clk = 1'b0, rst_n = 1'b0, dump = 1'b0, qp_read = 1'b0;
  logic [2:0] p_i = '0, p_q = '0, t_i = '0, t_q = '0;
  logic [15:0] res_ti, res_tq, res_pi, res_pq;
  logic new_data, accum_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int macc [4], mres [4];
  bit mflag, mirq;

  always #10 clk = ~clk;

  dual_arm_iad #(.MAX_PERIOD(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .dump(dump), .qp_read(qp_read),
    .p_i(p_i), .p_q(p_q), .t_i(t_i), .t_q(t_q),
    .res_ti(res_ti), .res_tq(res_tq), .res_pi(res_pi), .res_pq(res_pq),
    .new_data(new_data), .accum_irq(accum_irq)
  );

  function automatic int code(logic [2:0] c);
    return int'($signed(c));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " res_ti R5"}, int'($signed(res_ti)), mres[0]);
    chk({tag, " res_tq R5"}, int'($signed(res_tq)), mres[1]);
    chk({tag, " res_pi R3"}, int'($signed(res_pi)), mres[2]);
    chk({tag, " res_pq R3"}, int'($signed(res_pq)), mres[3]);
    chk({tag, " new_data R7/R8"}, int'(new_data), int'(mflag));
    chk({tag, " accum_irq R9"}, int'(accum_irq), int'(mirq));
  endtask

  task automatic step(logic d, logic r, logic [2:0] a, logic [2:0] b,
                      logic [2:0] c, logic [2:0] e);
    int s [4];
    dump = d; qp_read = r; p_i = a; p_q = b; t_i = c; t_q = e;
    s[0] = code(c); s[1] = code(e); s[2] = code(a); s[3] = code(b);
    @(posedge clk);
    @(negedge clk);
    mirq = d;
    if (d) mflag = 1'b1;
    else if (r) mflag = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (d) begin mres[k] = macc[k]; macc[k] = s[k]; end
      else macc[k] = macc[k] + s[k];
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin macc[k] = 0; mres[k] = 0; end
    mflag = 0; mirq = 0;
    // R1: reset holds everything at zero even with dump and samples active
    dump = 1; p_i = P3; p_q = M3; t_i = P1; t_q = M1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    dump = 0;
    @(posedge clk);
    @(negedge clk);
    macc[0] = code(P1); macc[1] = code(M1); macc[2] = code(P3); macc[3] = code(M3);
    check_all("R1 after release");

    // R2 R4 R5 R6 R8 R9: vector walk
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][13], VEC[v][12], VEC[v][11:9], VEC[v][8:6], VEC[v][5:3], VEC[v][2:0]);
      check_all($sformatf("R2 vec%0d", v));
    end

    // R3: a period of identical samples gives count times value
    step(1, 1, P1, P1, P1, P1);
    for (int n = 0; n < 9; n++) step(0, 0, P1, M1, P3, M3);
    step(1, 0, P3, P3, P3, P3);
    check_all("R3 ten-sample period");
    chk("R4 dump-cycle sample kept", int'($signed(res_pi)), 1 + 9);

    // R10: full-length period at the range edge
    step(1, 1, P3, P1, P1, M3);
    for (int n = 1; n < MAXP; n++) step(0, 0, P3, P1, P1, M3);
    step(1, 0, M3, P3, M1, P1);
    chk("R10 prompt I at +32766", int'($signed(res_pi)), 32766);
    chk("R10 track Q at -32766", int'($signed(res_tq)), -32766);
    check_all("R10 full period");

    // R8: read clears, second read no effect
    step(0, 1, P1, P1, P1, P1);
    chk("R8 read clears flag", int'(new_data), 0);
    step(0, 1, P1, P1, P1, P1);
    check_all("R8 read on clear flag");
    finish_run();
  end
endmodule